// File: doc/BRIEF.md
# Keyed Interrupt Steering Controller

This block takes four active-low peripheral interrupt request lines and steers each one onto one of sixteen active-high legacy interrupt outputs. A host programs the steering through a small indexed register file. The host first writes a register number to an index port, then reads or writes that register through a data port. Both ports share one simple synchronous strobe interface with an 8-bit address and 8-bit data.

The register file is guarded. After reset it is locked. It opens when the key value 0x0F is written to the identification register at index 0x02. Writing any other value to that register closes it again. While the file is closed, data-port traffic does nothing, with one exception: the key write itself. Firmware normally unlocks, programs or inspects one route register, and then locks again. The index port is never guarded.

Top module: `irq_steer_top`

## Requirements
- R1: A write strobe to address 0x22 loads the index register at the next clock edge. A read of 0x22 returns the index in the same cycle, whether the file is locked or unlocked.
- R2: A data-port (address 0x23) write of 0x0F while the index is 0x02 unlocks the file from the next cycle. This works from the locked state too. While unlocked, a data-port read at index 0x02 returns 0x0F.
- R3: A data-port write of any value other than 0x0F while the index is 0x02 locks the file from the next cycle.
- R4: While locked, data-port writes to route registers leave them unchanged, and every data-port read returns 0xFF.
- R5: While unlocked, indices 0x60, 0x61, 0x62 and 0x63 hold the route registers of request lines 0, 1, 2 and 3. A value written there reads back at the data port from the next cycle.
- R6: A route value with bit 7 set disables that line whatever bits 3:0 hold, and it is stored with bits 6:4 cleared.
- R7: A route value with bit 7 clear and bits 6:4 not all zero (16 to 127) routes the line to no output.
- R8: Output irq[n] is high exactly when at least one request line is low and has an enabled route selecting n. Several lines may share one output. The output follows the request inputs in the same cycle.
- R9: Outputs 0, 1, 2, 8 and 13 are never driven high, even though route values naming them are stored and read back.
- R10: After reset the file is locked, the index is 0x00, every route register holds 0x80, and all outputs are low.
- R11: While unlocked, a data-port read of an index with no register returns 0xFF, and a write to such an index changes no route register.
- R12: io_rdata is 0x00 whenever io_rd is low or the address is neither 0x22 nor 0x23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 8 | I/O address (0x22 index port, 0x23 data port) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the same cycle as io_rd |
| pirq_n | input | 4 | Active-low interrupt request lines |
| irq | output | 16 | Active-high steered interrupt outputs |

## Verification
A write takes effect at the clock edge that ends its strobe cycle. Its result can therefore first be seen one cycle later, both in read data and in the steering. Read data and the outputs are combinational from the current inputs and register state, so they are due in the same cycle as the read strobe or the request change. The bench drives inputs just after each rising edge. Its behavioural model updates on the same rising edge the design uses. Both outputs are compared at every falling edge, so every check falls inside the cycle in which its result is due.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int unsigned DEF_PIRQS  = 4;
  localparam int unsigned DEF_IRQS   = 16;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_ADDR_W = 8;

  // Store form of a route value: a set disable flag clears the bits between
  // the flag and the target field.
  function automatic logic [DEF_DATA_W-1:0] route_store(input logic [DEF_DATA_W-1:0] v,
                                                        input int unsigned sel_w);
    logic [DEF_DATA_W-1:0] r;
    r = v;
    if (v[DEF_DATA_W-1]) begin
      for (int b = 0; b < DEF_DATA_W - 1; b++)
        if (b >= sel_w) r[b] = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_PIRQ   = DEF_PIRQS,
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] IDX_PORT   = 8'h22,
  parameter logic [ADDR_W-1:0] DAT_PORT   = 8'h23,
  parameter logic [DATA_W-1:0] ID_INDEX   = 8'h02,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'h0F,
  parameter logic [DATA_W-1:0] ROUTE_BASE = 8'h60
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             io_wr,
  input  logic                             io_rd,
  input  logic [ADDR_W-1:0]                io_addr,
  input  logic [DATA_W-1:0]                io_wdata,
  output logic [DATA_W-1:0]                io_rdata,
  output logic [NUM_PIRQ-1:0][DATA_W-1:0]  route_o
);
  localparam logic [DATA_W-1:0] ROUTE_RST = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ALL_ONES  = '1;

  logic [DATA_W-1:0]               idx_q;
  logic                            unl_q;
  logic [NUM_PIRQ-1:0][DATA_W-1:0] route_q;
  logic [NUM_PIRQ-1:0]             hit;

  logic idx_wr, dat_wr, id_sel;
  assign idx_wr = io_wr && (io_addr == IDX_PORT);
  assign dat_wr = io_wr && (io_addr == DAT_PORT);
  assign id_sel = (idx_q == ID_INDEX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               unl_q <= 1'b0;
    else if (dat_wr && id_sel) unl_q <= (io_wdata == UNLOCK_KEY);
  end

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_route
    localparam logic [DATA_W-1:0] MY_IDX = DATA_W'(ROUTE_BASE + p);
    assign hit[p] = (idx_q == MY_IDX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          route_q[p] <= ROUTE_RST;
      else if (dat_wr && unl_q && hit[p])  route_q[p] <= route_store(io_wdata, SEL_W);
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && io_addr == IDX_PORT) begin
      io_rdata = idx_q;
    end else if (io_rd && io_addr == DAT_PORT) begin
      io_rdata = ALL_ONES;
      if (unl_q) begin
        if (id_sel) io_rdata = UNLOCK_KEY;
        for (int p = 0; p < NUM_PIRQ; p++)
          if (hit[p]) io_rdata = route_q[p];
      end
    end
  end

  assign route_o = route_q;

  // Assertions
  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IDX_PORT) |=> (idx_q == $past(io_wdata)));
  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && id_sel && io_wdata == UNLOCK_KEY) |=> unl_q);
  p_other_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && id_sel && io_wdata != UNLOCK_KEY) |=> !unl_q);
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && dat_wr) |=> $stable(route_q));
  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && io_rd && io_addr == DAT_PORT) |-> (io_rdata == ALL_ONES));
  p_idle_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd) |-> (io_rdata == '0));
endmodule

// File: rtl/irq_steer_xbar.sv
module irq_steer_xbar
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = DEF_PIRQS,
  parameter int unsigned NUM_IRQ  = DEF_IRQS,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter logic [NUM_IRQ-1:0] BLOCKED_MASK = 16'h2107
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PIRQ-1:0][DATA_W-1:0] route_i,
  input  logic [NUM_PIRQ-1:0]             pirq_n_i,
  output logic [NUM_IRQ-1:0]              irq_o
);
  logic [NUM_PIRQ-1:0]              line_on;
  logic [NUM_PIRQ-1:0][NUM_IRQ-1:0] line_vec;

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_line
    // Enabled only when every bit above the target field is clear.
    assign line_on[p] = (route_i[p][DATA_W-1:SEL_W] == '0) && !pirq_n_i[p];
    always_comb begin
      line_vec[p] = '0;
      if (line_on[p]) line_vec[p][route_i[p][SEL_W-1:0]] = 1'b1;
    end
  end

  always_comb begin
    irq_o = '0;
    for (int p = 0; p < NUM_PIRQ; p++) irq_o = irq_o | line_vec[p];
    irq_o = irq_o & ~BLOCKED_MASK;
  end

  p_blocked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & BLOCKED_MASK) == '0));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&pirq_n_i) |-> (irq_o == '0));
  p_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_o) <= NUM_PIRQ));
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = DEF_PIRQS,
  parameter int unsigned NUM_IRQ  = DEF_IRQS,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter logic [NUM_IRQ-1:0] BLOCKED_MASK = 16'h2107
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic [DATA_W-1:0]   io_rdata,
  input  logic [NUM_PIRQ-1:0] pirq_n,
  output logic [NUM_IRQ-1:0]  irq
);
  localparam int unsigned SEL_W = $clog2(NUM_IRQ);

  logic [NUM_PIRQ-1:0][DATA_W-1:0] route;

  irq_steer_regs #(
    .NUM_PIRQ(NUM_PIRQ), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .route_o(route)
  );

  irq_steer_xbar #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W), .DATA_W(DATA_W),
    .BLOCKED_MASK(BLOCKED_MASK)
  ) u_xbar (
    .clk(clk), .rst_n(rst_n), .route_i(route), .pirq_n_i(pirq_n), .irq_o(irq)
  );

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n)) |-> (irq == '0));
endmodule

// File: tb/irq_steer_top_tb_top.sv
`timescale 1ns/1ps
module irq_steer_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic [7:0] io_rdata;
  logic [3:0] pirq_n = 4'hF;
  logic [15:0] irq;

  int checks = 0, errors = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  irq_steer_top dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pirq_n(pirq_n), .irq(irq)
  );

  // Behavioural reference model
  int m_idx, m_unl;
  int m_route[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_unl = 0;
      foreach (m_route[i]) m_route[i] = 128;
    end else if (io_wr) begin
      if (io_addr == 8'h22) m_idx = io_wdata;
      else if (io_addr == 8'h23) begin
        if (m_idx == 2) m_unl = (io_wdata == 8'h0F);
        else if (m_unl != 0 && m_idx >= 96 && m_idx <= 99)
          m_route[m_idx-96] = (io_wdata >= 128) ? (128 + (io_wdata % 16)) : int'(io_wdata);
      end
    end
  end

  function automatic int exp_rdata();
    if (!io_rd) return 0;
    if (io_addr == 8'h22) return m_idx;
    if (io_addr != 8'h23) return 0;
    if (m_unl == 0) return 255;
    if (m_idx == 2) return 15;
    if (m_idx >= 96 && m_idx <= 99) return m_route[m_idx-96];
    return 255;
  endfunction

  function automatic int exp_irq();
    int v = 0;
    for (int p = 0; p < 4; p++) begin
      int r = m_route[p];
      if (!pirq_n[p] && r < 16 && r != 0 && r != 1 && r != 2 && r != 8 && r != 13)
        v = v | (1 << r);
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(io_rdata) != exp_rdata()) begin
        errors++;
        $display("FAIL %s io_rdata actual=%0h expected=%0h t=%0t", cur_req, io_rdata, exp_rdata(), $time);
      end
      checks++;
      if (int'(irq) != exp_irq()) begin
        errors++;
        $display("FAIL %s irq actual=%0h expected=%0h t=%0t", cur_req, irq, exp_irq(), $time);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_wr = 1; io_addr = a; io_wdata = d; cyc(); io_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a);
    io_rd = 1; io_addr = a; cyc(); io_rd = 0;
  endtask
  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(8'h22, i); wr(8'h23, d);
  endtask
  task automatic reg_rd(input logic [7:0] i);
    wr(8'h22, i); rd(8'h23);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: reset state
    cur_req = "R10"; rd(8'h22); reg_rd(8'h60); pirq_n = 4'h0; cyc(); pirq_n = 4'hF;
    // R1: index port while locked
    cur_req = "R1"; wr(8'h22, 8'hA5); rd(8'h22); wr(8'h22, 8'h61); rd(8'h22);
    // R4: locked access ignored
    cur_req = "R4"; reg_wr(8'h60, 8'h05); reg_rd(8'h60); pirq_n = 4'h0; cyc(); pirq_n = 4'hF;
    reg_rd(8'h02);
    // R2: unlock
    cur_req = "R2"; reg_wr(8'h02, 8'h0F); rd(8'h23);
    // R5: route registers
    cur_req = "R5";
    for (int p = 0; p < 4; p++) reg_wr(8'(8'h60 + p), 8'(3 + p));
    for (int p = 0; p < 4; p++) reg_rd(8'(8'h60 + p));
    // R8: steering, single and shared
    cur_req = "R8";
    for (int k = 0; k < 16; k++) begin pirq_n = 4'(k); cyc(); end
    reg_wr(8'h61, 8'h03); reg_wr(8'h63, 8'h03);
    for (int k = 0; k < 16; k++) begin pirq_n = 4'(k); cyc(); end
    pirq_n = 4'h0;
    for (int t = 0; t < 16; t++) begin reg_wr(8'h60, 8'(t)); rd(8'h23); end
    // R9: blocked outputs
    cur_req = "R9";
    reg_wr(8'h60, 8'h00); reg_wr(8'h61, 8'h08); reg_wr(8'h62, 8'h0D); reg_wr(8'h63, 8'h02); reg_rd(8'h62);
    // R6: disable flag
    cur_req = "R6";
    reg_wr(8'h60, 8'hF5); reg_rd(8'h60); reg_wr(8'h61, 8'h8B); reg_rd(8'h61); reg_wr(8'h62, 8'h07); cyc();
    // R7: out-of-range value
    cur_req = "R7";
    reg_wr(8'h62, 8'h17); reg_rd(8'h62); reg_wr(8'h63, 8'h7A); reg_rd(8'h63);
    reg_wr(8'h63, 8'h0A); cyc();
    // R11: unimplemented indices
    cur_req = "R11";
    reg_wr(8'h64, 8'h04); reg_rd(8'h64); reg_wr(8'h5F, 8'h06); reg_rd(8'h5F);
    for (int p = 0; p < 4; p++) reg_rd(8'(8'h60 + p));
    // R12: read data idle
    cur_req = "R12"; rd(8'h21); rd(8'h24); io_addr = 8'h23; cyc();
    // R3: lock again, then R4 behaviour
    cur_req = "R3"; reg_wr(8'h02, 8'h00); rd(8'h23); reg_wr(8'h63, 8'h05); reg_rd(8'h63);
    reg_wr(8'h02, 8'h0E); reg_wr(8'h02, 8'h1F);
    cur_req = "R2"; reg_wr(8'h02, 8'h0F); reg_rd(8'h63); reg_wr(8'h02, 8'h10); reg_rd(8'h63);
    pirq_n = 4'hF; cyc(); cyc();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule